// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides one XLEN-bit integer by another, one quotient bit per clock cycle, using the restoring method. At each step the divisor is subtracted from the partial remainder. When the difference is negative, the divisor is added back and the quotient bit is 0. Otherwise the quotient bit is 1. A two-bit operation code chooses between a quotient and a remainder, and between signed and unsigned operands. Signed operations work on the magnitudes of the operands and correct the signs at the end.

The block never raises an error. A zero divisor, and the one signed case whose quotient cannot be represented, each return a fixed result. Both finish in a single cycle without iterating.

A request is made by pulsing `start` while `busy` is low. `done` pulses for one cycle when `result` is valid. `result` then holds until the next accepted request.

Top module: `divr_unit`

## Requirements
- R1: `op` selects the operation. Bit 0 picks the remainder (1) or the quotient (0). Bit 1 picks unsigned (1) or signed two's-complement (0) operands. So 00 is signed quotient, 01 signed remainder, 10 unsigned quotient and 11 unsigned remainder.
- R2: For unsigned operations with a nonzero divisor, `result` is the truncated quotient (op 10) or the remainder (op 11) of `dividend` divided by `divisor`.
- R3: For signed operations outside the special cases, the quotient is truncated toward zero. It is negative when exactly one operand is negative. The remainder takes the sign of the dividend.
- R4: With `divisor` equal to zero, any quotient operation returns all ones and any remainder operation returns `dividend`.
- R5: For a signed operation with the most negative `dividend` and `divisor` equal to -1, the quotient is `dividend` and the remainder is 0.
- R6: The cases of R4 and R5 raise `done` on the clock edge after the one that accepts `start`, and `busy` stays low. Every other request holds `busy` high for XLEN+1 cycles, and `done` rises XLEN+1 edges after the accepting edge.
- R7: `done` is high for exactly one cycle per request, and never while `busy` is high.
- R8: `start` is ignored while `busy` is high. `result` changes only when `done` rises.
- R9: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted while `busy` is low |
| op | input | 2 | Operation code (see R1) |
| dividend | input | XLEN | Dividend |
| divisor | input | XLEN | Divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | XLEN | Selected quotient or remainder |

## Verification
A wrong partial remainder, or a wrong quotient bit in any step, propagates into `result`. Only the value presented with `done` exposes it, XLEN+1 cycles after the request. A fault in the step counter shows up sooner and more directly, as a shift in the cycle where `done` rises relative to `start`. Sign-flag errors appear only for signed operands with mixed signs. Errors in the special-case paths show up in the very next cycle.

// File: rtl/divr_pkg.sv
package divr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } divr_state_e;

    function automatic logic op_wants_rem(input logic [1:0] op);
        return op[0];
    endfunction

    function automatic logic op_unsigned(input logic [1:0] op);
        return op[1];
    endfunction

endpackage

// File: rtl/divr_prep.sv
module divr_prep #(
    parameter int XLEN = 32
) (
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic [XLEN-1:0] mag_a,
    output logic [XLEN-1:0] mag_b,
    output logic            neg_q,
    output logic            neg_r,
    output logic            zero_div,
    output logic            ovf
);
    import divr_pkg::*;

    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    logic sgn_a, sgn_b;

    always_comb begin
        sgn_a    = !op_unsigned(op) && dividend[XLEN-1];
        sgn_b    = !op_unsigned(op) && divisor[XLEN-1];
        mag_a    = sgn_a ? (~dividend + 1'b1) : dividend;
        mag_b    = sgn_b ? (~divisor + 1'b1) : divisor;
        neg_q    = sgn_a ^ sgn_b;
        neg_r    = sgn_a;
        zero_div = (divisor == '0);
        ovf      = !op_unsigned(op) && (dividend == MOST_NEG) && (divisor == '1);
    end

endmodule

// File: rtl/divr_step.sv
module divr_step #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] rem_in,
    input  logic [XLEN-1:0] quo_in,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN-1:0] rem_out,
    output logic [XLEN-1:0] quo_out
);
    localparam int W = XLEN + 2;

    logic [W-1:0] shifted, trial, restored, rem_full;
    logic [1:0]   unused_hi;
    logic         qbit;

    always_comb begin
        shifted  = {1'b0, rem_in, quo_in[XLEN-1]};
        trial    = shifted - {2'b00, dvs};
        restored = trial + {2'b00, dvs};
        if (trial[W-1]) begin
            rem_full = restored;
            qbit     = 1'b0;
        end else begin
            rem_full = trial;
            qbit     = 1'b1;
        end
        rem_out   = rem_full[XLEN-1:0];
        unused_hi = rem_full[W-1:XLEN];
        quo_out   = {quo_in[XLEN-2:0], qbit};
    end

endmodule

// File: rtl/divr_fix.sv
module divr_fix #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] rem,
    input  logic            neg_q,
    input  logic            neg_r,
    input  logic            sel_rem,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0] q_s, r_s;

    always_comb begin
        q_s = neg_q ? (~quo + 1'b1) : quo;
        r_s = neg_r ? (~rem + 1'b1) : rem;
        res = sel_rem ? r_s : q_s;
    end

endmodule

// File: rtl/divr_unit.sv
module divr_unit #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);
    import divr_pkg::*;

    localparam int CW = $clog2(XLEN + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(XLEN - 1);

    typedef struct packed {
        divr_state_e     state;
        logic [CW-1:0]   cnt;
        logic [XLEN-1:0] rem;
        logic [XLEN-1:0] quo;
        logic [XLEN-1:0] dvs;
        logic            neg_q;
        logic            neg_r;
        logic            sel_rem;
        logic            done;
        logic [XLEN-1:0] result;
    } divr_regs_t;

    divr_regs_t st_d, st_q;

    logic [XLEN-1:0] mag_a, mag_b, step_rem, step_quo, fix_res;
    logic            neg_q, neg_r, zero_div, ovf;

    divr_prep #(.XLEN(XLEN)) u_prep (
        .op(op), .dividend(dividend), .divisor(divisor),
        .mag_a(mag_a), .mag_b(mag_b), .neg_q(neg_q), .neg_r(neg_r),
        .zero_div(zero_div), .ovf(ovf)
    );

    divr_step #(.XLEN(XLEN)) u_step (
        .rem_in(st_q.rem), .quo_in(st_q.quo), .dvs(st_q.dvs),
        .rem_out(step_rem), .quo_out(step_quo)
    );

    divr_fix #(.XLEN(XLEN)) u_fix (
        .quo(st_q.quo), .rem(st_q.rem), .neg_q(st_q.neg_q),
        .neg_r(st_q.neg_r), .sel_rem(st_q.sel_rem), .res(fix_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (zero_div) begin
                        st_d.result = op_wants_rem(op) ? dividend : '1;
                        st_d.done   = 1'b1;
                    end else if (ovf) begin
                        st_d.result = op_wants_rem(op) ? '0 : dividend;
                        st_d.done   = 1'b1;
                    end else begin
                        st_d.state   = ST_RUN;
                        st_d.cnt     = '0;
                        st_d.rem     = '0;
                        st_d.quo     = mag_a;
                        st_d.dvs     = mag_b;
                        st_d.neg_q   = neg_q;
                        st_d.neg_r   = neg_r;
                        st_d.sel_rem = op_wants_rem(op);
                    end
                end
            end
            ST_RUN: begin
                st_d.rem = step_rem;
                st_d.quo = step_quo;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST_STEP) begin
                    st_d.state = ST_FIX;
                end
            end
            ST_FIX: begin
                st_d.result = fix_res;
                st_d.done   = 1'b1;
                st_d.state  = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.state != ST_IDLE);
    assign done   = st_q.done;
    assign result = st_q.result;

endmodule

// File: rtl/divr_unit_chk.sv
module divr_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [1:0]      op,
    input logic [XLEN-1:0] dividend,
    input logic [XLEN-1:0] divisor,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result
);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    int unsigned busy_cnt;
    logic        take, special;

    assign take    = start && !busy;
    assign special = (divisor == '0) ||
                     (!op[1] && dividend == MOST_NEG && divisor == '1);

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= 0;
        else                 busy_cnt <= busy_cnt + 1;
    end

    a_r4_zero_quo: assert property (@(posedge clk) disable iff (!rst_n)
        take && divisor == '0 && !op[0] |=> done && result == '1);

    a_r4_zero_rem: assert property (@(posedge clk) disable iff (!rst_n)
        take && divisor == '0 && op[0] |=> done && result == $past(dividend));

    a_r5_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        take && !op[1] && dividend == MOST_NEG && divisor == '1 |=>
        done && result == ($past(op[0]) ? '0 : $past(dividend)));

    a_r6_iterate: assert property (@(posedge clk) disable iff (!rst_n)
        take && !special |=> busy && !done);

    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(busy) |-> busy_cnt == XLEN + 1);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy || !start |=> done || $stable(result));

endmodule

bind divr_unit divr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .result(result)
);

// File: tb/divr_unit_bench.sv
module divr_unit_bench;
    localparam int XLEN = 32;
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      op = 2'b00;
    logic [XLEN-1:0] dividend = '0;
    logic [XLEN-1:0] divisor = '0;
    logic            busy, done;
    logic [XLEN-1:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    divr_unit #(.XLEN(XLEN)) u_divr_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] model(input logic [1:0] o,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
        if (b == '0) return o[0] ? a : '1;
        if (!o[1] && a == MOST_NEG && b == '1) return o[0] ? '0 : a;
        case (o)
            2'b00:   return $signed(a) / $signed(b);
            2'b01:   return $signed(a) % $signed(b);
            2'b10:   return a / b;
            default: return a % b;
        endcase
    endfunction

    function automatic bit is_special(input logic [1:0] o,
                                      input logic [XLEN-1:0] a,
                                      input logic [XLEN-1:0] b);
        return (b == '0) || (!o[1] && a == MOST_NEG && b == '1);
    endfunction

    // Issues one request, checks value, done latency and busy behaviour.
    task automatic run_op(input string req, input logic [1:0] o,
                          input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
        int k;
        int exp_k;
        logic [XLEN-1:0] exp_v;
        exp_v = model(o, a, b);
        exp_k = is_special(o, a, b) ? 1 : XLEN + 2;
        @(negedge clk);
        op = o; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == (exp_k != 1), req, "busy after accept", XLEN'(busy), XLEN'(exp_k != 1));
        k = 1;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        check(result == exp_v, req, "result", result, exp_v);
        check(k == exp_k, "R6", "done latency", XLEN'(k), XLEN'(exp_k));
        check(!busy, "R7", "busy with done", XLEN'(busy), '0);
        @(negedge clk);
        check(!done, "R7", "done pulse width", XLEN'(done), '0);
        check(result == exp_v, "R8", "result held", result, exp_v);
    endtask

    task automatic t_reset;
        check(!busy && !done && result == '0, "R9", "reset state",
              {result[XLEN-3:0], busy, done}, '0);
    endtask

    task automatic t_unsigned;
        run_op("R2", 2'b10, 32'd100, 32'd7);
        run_op("R2", 2'b11, 32'd100, 32'd7);
        run_op("R2", 2'b10, 32'hFFFF_FFFF, 32'd1);
        run_op("R2", 2'b11, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
        run_op("R2", 2'b10, 32'd5, 32'd9);
        run_op("R1", 2'b11, 32'h8000_0000, 32'hFFFF_FFFF);
    endtask

    task automatic t_signed;
        run_op("R3", 2'b00, -32'sd7, 32'sd2);
        run_op("R3", 2'b01, -32'sd7, 32'sd2);
        run_op("R3", 2'b00, 32'sd7, -32'sd2);
        run_op("R3", 2'b01, 32'sd7, -32'sd2);
        run_op("R3", 2'b00, -32'sd100, -32'sd9);
        run_op("R3", 2'b01, -32'sd100, -32'sd9);
        run_op("R1", 2'b00, MOST_NEG, 32'sd2);
        run_op("R1", 2'b01, MOST_NEG, 32'sd3);
    endtask

    task automatic t_zero_div;
        run_op("R4", 2'b00, 32'h1234_5678, '0);
        run_op("R4", 2'b01, 32'h8765_4321, '0);
        run_op("R4", 2'b10, 32'd0, '0);
        run_op("R4", 2'b11, 32'hDEAD_BEEF, '0);
    endtask

    task automatic t_overflow;
        run_op("R5", 2'b00, MOST_NEG, '1);
        run_op("R5", 2'b01, MOST_NEG, '1);
        run_op("R2", 2'b10, MOST_NEG, '1);
    endtask

    task automatic t_busy_ignore;
        int k;
        logic [XLEN-1:0] exp_v;
        exp_v = 32'd1000 / 32'd3;
        @(negedge clk);
        op = 2'b10; dividend = 32'd1000; divisor = 32'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        repeat (4) begin @(negedge clk); k++; end
        op = 2'b11; dividend = 32'd77; divisor = '0; start = 1'b1;
        @(negedge clk);
        k++;
        start = 1'b0;
        check(!done && busy, "R8", "start while busy", XLEN'(done), '0);
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        check(result == exp_v, "R8", "first request kept", result, exp_v);
        check(k == XLEN + 2, "R8", "latency unchanged", XLEN'(k), XLEN'(XLEN + 2));
        repeat (3) @(negedge clk);
        check(result == exp_v && !done, "R8", "idle hold", result, exp_v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_zero_div();
        t_overflow();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule